// File: doc/BRIEF.md
# Ethernet MAC Pause Flow Control

This block handles flow control beside the receive and transmit paths of a 10/100 Ethernet MAC. On the receive side it follows the incoming byte stream and recognises valid PAUSE control frames. For every frame it produces a status word. When a PAUSE frame arrives with flow control enabled in full duplex, it loads a pause counter that holds off the transmitter for a whole number of slot times.

On the transmit side it accepts a request to send flow-control traffic. In full duplex this is a PAUSE frame, and in half duplex it is backpressure. It passes the request to the frame transmitter through a request/done handshake and shows a busy flag for as long as that transmission lasts.

The block forwards every frame and only produces status. The application decides from the filter bit whether to keep or drop a frame. Software is expected to wait for the busy flag to read low before it changes the flow-control settings, and to write 0 to the busy position when it does.

Top module: `pause_flow_ctrl`

## Requirements
- R1: While `cfgFlowEn` is 0, no frame is decoded as a PAUSE frame. The pause counter is cleared, so `txInhibit` is 0 from the next cycle. `fcSendReq` is ignored.
- R2: A valid PAUSE frame has the bytes 01 80 C2 00 00 01 at stream positions 0..5, 88 08 at 12..13 and 00 01 at 14..15. Positions 16..17 carry the pause value, most significant byte first. The frame has at least 18 bytes and `rxCrcOk` is high with `rxEnd`. If such a frame arrives with `cfgFlowEn` and `cfgFullDuplex` both 1, `txInhibit` is 1 from the cycle after `rxEnd` and stays 1 for exactly that many `slotTick` pulses.
- R3: In half duplex (`cfgFullDuplex`=0), a valid PAUSE frame leaves `txInhibit` unchanged.
- R4: Every frame gets a status. This includes frames with a bad CRC, short frames and frames that do not match. `rxStatValid` pulses for one cycle, in the cycle after each `rxEnd`.
- R5: When `cfgPromisc` is 0, `rxStatFilter` equals `cfgPassCtl` for a valid PAUSE frame decoded with `cfgFlowEn`=1. For every other frame it is 0.
- R6: When `cfgPromisc` is 1, `rxStatFilter` is 1 for every frame, whatever the value of `cfgPassCtl`.
- R7: A new valid PAUSE frame reloads the counter with its own value. A pause value of 0 drops `txInhibit` in the cycle after `rxEnd`.
- R8: If `fcSendReq` is high while `cfgFlowEn`=1 and the block is idle, `txFcReq` and `fcBusy` are 1 from the next cycle. They stay 1 until the cycle after `txFcDone`. `txFcBackpressure` is 1 when the request was taken in half duplex and 0 when it was taken in full duplex.
- R9: A frame with a bad CRC, a wrong header byte, or fewer than 18 bytes is not treated as a PAUSE frame.
- R10: A `fcSendReq` that arrives while `fcBusy` is 1 is ignored and does not change `txFcBackpressure`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | `rxByte` is valid this cycle |
| rxStart | input | 1 | First byte of a frame (together with `rxValid`) |
| rxEnd | input | 1 | Frame end strobe, given in a cycle with no byte |
| rxCrcOk | input | 1 | CRC good, sampled with `rxEnd` |
| cfgFlowEn | input | 1 | Flow-control enable |
| cfgPassCtl | input | 1 | Mark valid PAUSE frames in the status |
| cfgFullDuplex | input | 1 | 1 = full duplex, 0 = half duplex |
| cfgPromisc | input | 1 | Promiscuous filtering mode |
| slotTick | input | 1 | One pulse per slot time |
| fcSendReq | input | 1 | Request to send PAUSE or backpressure |
| txFcDone | input | 1 | Transmitter has finished the flow-control transmission |
| txInhibit | output | 1 | Hold off the transmitter |
| txFcReq | output | 1 | Request to the frame transmitter |
| txFcBackpressure | output | 1 | 1 = backpressure, 0 = PAUSE frame |
| fcBusy | output | 1 | Flow-control transmission in progress |
| rxStatValid | output | 1 | Status strobe, one per frame |
| rxStatFilter | output | 1 | Packet-filter status bit |

## Verification
All results are registered once. The status strobe and filter bit, and any load or release of `txInhibit`, appear in the cycle after `rxEnd`. Each `slotTick` and each `txFcDone` takes effect in the cycle after it, and so does the request and busy response to `fcSendReq`. The bench drives inputs on the falling edge and checks each result on the next falling edge, which is the first half-cycle after the rising edge that registers it. A sweep covers every combination of the four configuration bits against good, corrupted and short frames, each with a good and a bad CRC. Countdown, reload and handshake sequences are then checked tick by tick.

// File: rtl/pause_flow_pkg.sv
package pause_flow_pkg;

  localparam int unsigned HDR_LEN   = 16;
  localparam int unsigned FRAME_MIN = 18;
  localparam int unsigned PAUSE_W   = 16;

  typedef struct packed {
    logic loadTimer;
    logic clearTimer;
  } pauseStrobe_t;

  function automatic logic [7:0] hdrByte(input int unsigned idx);
    logic [7:0] b;
    case (idx)
      0:  b = 8'h01;
      1:  b = 8'h80;
      2:  b = 8'hC2;
      3:  b = 8'h00;
      4:  b = 8'h00;
      5:  b = 8'h01;
      12: b = 8'h88;
      13: b = 8'h08;
      14: b = 8'h00;
      15: b = 8'h01;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic hdrChecked(input int unsigned idx);
    return (idx < 6) || (idx >= 12 && idx < HDR_LEN);
  endfunction

endpackage

// File: rtl/pause_flow_dp.sv
module pause_flow_dp
  import pause_flow_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   rxByte,
  input  logic         rxValid,
  input  logic         rxStart,
  input  logic         slotTick,
  input  pauseStrobe_t strobes,
  output logic         frameIsPause,
  output logic         timerBusy
);

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0]   byteCnt;
  logic [CNT_W-1:0]   curIdx;
  logic               matchOk;
  logic [PAUSE_W-1:0] pauseVal;
  logic [TIMER_W-1:0] timer;

  assign curIdx = rxStart ? '0 : byteCnt;

  // Byte position tracking and header comparison
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt  <= '0;
      matchOk  <= 1'b0;
      pauseVal <= '0;
    end else if (rxValid) begin
      if (int'(curIdx) != CNT_MAX) byteCnt <= curIdx + 1'b1;
      else                          byteCnt <= curIdx;
      if (rxStart) begin
        matchOk <= (rxByte == hdrByte(0));
      end else if (hdrChecked(int'(curIdx)) && rxByte != hdrByte(int'(curIdx))) begin
        matchOk <= 1'b0;
      end
      if (int'(curIdx) == HDR_LEN)     pauseVal[15:8] <= rxByte;
      if (int'(curIdx) == HDR_LEN + 1) pauseVal[7:0]  <= rxByte;
    end
  end

  assign frameIsPause = matchOk && (int'(byteCnt) >= FRAME_MIN);

  // Pause counter in slot times
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobes.clearTimer) begin
      timer <= '0;
    end else if (strobes.loadTimer) begin
      timer <= TIMER_W'(pauseVal);
    end else if (slotTick && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign timerBusy = (timer != '0);

endmodule

// File: rtl/pause_flow_ctl.sv
module pause_flow_ctl
  import pause_flow_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxEnd,
  input  logic         rxCrcOk,
  input  logic         cfgFlowEn,
  input  logic         cfgPassCtl,
  input  logic         cfgFullDuplex,
  input  logic         cfgPromisc,
  input  logic         frameIsPause,
  input  logic         fcSendReq,
  input  logic         txFcDone,
  output pauseStrobe_t strobes,
  output logic         rxStatValid,
  output logic         rxStatFilter,
  output logic         txFcReq,
  output logic         txFcBackpressure,
  output logic         fcBusy
);

  typedef enum logic {TX_IDLE, TX_SENDING} txState_t;

  txState_t txState;
  logic     validPause;

  assign validPause         = rxEnd && rxCrcOk && frameIsPause && cfgFlowEn;
  assign strobes.clearTimer = !cfgFlowEn;
  assign strobes.loadTimer  = validPause && cfgFullDuplex;

  // Per-frame status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxStatValid  <= 1'b0;
      rxStatFilter <= 1'b0;
    end else begin
      rxStatValid <= rxEnd;
      if (rxEnd) rxStatFilter <= cfgPromisc | (validPause & cfgPassCtl);
    end
  end

  // Flow-control transmit handshake
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState          <= TX_IDLE;
      txFcBackpressure <= 1'b0;
    end else begin
      case (txState)
        TX_IDLE: if (fcSendReq && cfgFlowEn) begin
          txState          <= TX_SENDING;
          txFcBackpressure <= !cfgFullDuplex;
        end
        TX_SENDING: if (txFcDone) txState <= TX_IDLE;
        default: txState <= TX_IDLE;
      endcase
    end
  end

  assign txFcReq = (txState == TX_SENDING);
  assign fcBusy  = (txState == TX_SENDING);

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
  import pause_flow_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rxByte,
  input  logic       rxValid,
  input  logic       rxStart,
  input  logic       rxEnd,
  input  logic       rxCrcOk,
  input  logic       cfgFlowEn,
  input  logic       cfgPassCtl,
  input  logic       cfgFullDuplex,
  input  logic       cfgPromisc,
  input  logic       slotTick,
  input  logic       fcSendReq,
  input  logic       txFcDone,
  output logic       txInhibit,
  output logic       txFcReq,
  output logic       txFcBackpressure,
  output logic       fcBusy,
  output logic       rxStatValid,
  output logic       rxStatFilter
);

  pauseStrobe_t strobes;
  logic         frameIsPause;
  logic         timerBusy;

  pause_flow_dp #(.TIMER_W(TIMER_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .rxStart(rxStart), .slotTick(slotTick), .strobes(strobes),
    .frameIsPause(frameIsPause), .timerBusy(timerBusy)
  );

  pause_flow_ctl i_ctl (
    .clk(clk), .rstN(rstN), .rxEnd(rxEnd), .rxCrcOk(rxCrcOk),
    .cfgFlowEn(cfgFlowEn), .cfgPassCtl(cfgPassCtl),
    .cfgFullDuplex(cfgFullDuplex), .cfgPromisc(cfgPromisc),
    .frameIsPause(frameIsPause), .fcSendReq(fcSendReq), .txFcDone(txFcDone),
    .strobes(strobes), .rxStatValid(rxStatValid), .rxStatFilter(rxStatFilter),
    .txFcReq(txFcReq), .txFcBackpressure(txFcBackpressure), .fcBusy(fcBusy)
  );

  assign txInhibit = timerBusy;

endmodule

// File: rtl/pause_flow_chk.sv
module pause_flow_chk (
  input logic clk,
  input logic rstN,
  input logic rxEnd,
  input logic cfgFlowEn,
  input logic cfgFullDuplex,
  input logic cfgPromisc,
  input logic fcSendReq,
  input logic txFcDone,
  input logic txInhibit,
  input logic txFcBackpressure,
  input logic fcBusy,
  input logic rxStatValid,
  input logic rxStatFilter
);

  AST_DISABLED_NO_INHIBIT: assert property (@(posedge clk) disable iff (!rstN)
    !cfgFlowEn |=> !txInhibit); // R1

  AST_INHIBIT_RISES_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (!txInhibit && !rxEnd) |=> !txInhibit); // R2

  AST_HALF_DUPLEX_NO_PAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!txInhibit && !cfgFullDuplex) |=> !txInhibit); // R3

  AST_STATUS_PER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    rxEnd |=> rxStatValid); // R4

  AST_STATUS_ONLY_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnd |=> !rxStatValid); // R4

  AST_PROMISC_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnd && cfgPromisc) |=> rxStatFilter); // R6

  AST_BUSY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (fcBusy && !txFcDone) |=> fcBusy); // R8

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (fcBusy && txFcDone) |=> !fcBusy); // R8

  AST_KIND_STABLE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (fcBusy && fcSendReq) |=> $stable(txFcBackpressure)); // R10

endmodule

bind pause_flow_ctrl pause_flow_chk i_chk (.*);

// File: tb/test_pause_flow_ctrl.sv
module test_pause_flow_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rxByte = '0;
  logic       rxValid = 1'b0, rxStart = 1'b0, rxEnd = 1'b0, rxCrcOk = 1'b0;
  logic       cfgFlowEn = 1'b0, cfgPassCtl = 1'b0, cfgFullDuplex = 1'b0, cfgPromisc = 1'b0;
  logic       slotTick = 1'b0, fcSendReq = 1'b0, txFcDone = 1'b0;
  logic       txInhibit, txFcReq, txFcBackpressure, fcBusy, rxStatValid, rxStatFilter;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pause_flow_ctrl i_pause_flow_ctrl (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // kind: 0 good, 1 bad address, 2 bad opcode, 3 bad type, 4 short
  function automatic logic [7:0] frameByte(int kind, int idx, logic [15:0] pv);
    logic [7:0] b;
    case (idx)
      0: b = 8'h01; 1: b = 8'h80; 2: b = 8'hC2; 3: b = 8'h00; 4: b = 8'h00;
      5: b = (kind == 1) ? 8'h02 : 8'h01;
      12: b = 8'h88;
      13: b = (kind == 3) ? 8'h09 : 8'h08;
      14: b = 8'h00;
      15: b = (kind == 2) ? 8'h02 : 8'h01;
      16: b = pv[15:8];
      17: b = pv[7:0];
      default: b = (idx > 5 && idx < 12) ? 8'h20 + 8'(idx) : 8'h00;
    endcase
    return b;
  endfunction

  // Ends on the negedge where status and timer results are visible
  task automatic sendFrame(input int kind, input logic [15:0] pv, input logic crc);
    int len;
    len = (kind == 4) ? 17 : 20;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxStart = (i == 0); rxByte = frameByte(kind, i, pv);
    end
    @(negedge clk);
    rxValid = 1'b0; rxStart = 1'b0; rxEnd = 1'b1; rxCrcOk = crc;
    @(negedge clk);
    rxEnd = 1'b0; rxCrcOk = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); slotTick = 1'b1;
    @(negedge clk); slotTick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R4 reset status", rxStatValid, 1'b0);
    chk("R8 reset busy", fcBusy, 1'b0);
    chk("R1 reset inhibit", txInhibit, 1'b0);
    rstN = 1'b1;

    // Configuration sweep against frame kinds and CRC
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int kind = 0; kind < 5; kind++) begin
        for (int crc = 0; crc < 2; crc++) begin
          logic vp, expFilt, expInh;
          @(negedge clk); cfgFlowEn = 1'b0;
          @(negedge clk);
          cfgFlowEn = cfg[0]; cfgPassCtl = cfg[1];
          cfgFullDuplex = cfg[2]; cfgPromisc = cfg[3];
          sendFrame(kind, 16'h0003, crc[0]);
          vp = (kind == 0) && crc[0] && cfg[0];
          expFilt = cfg[3] | (vp & cfg[1]);
          expInh = vp & cfg[2];
          chk("R4 status strobe", rxStatValid, 1'b1);
          chk(cfg[3] ? "R6 promisc filter" : "R5 R9 filter bit", rxStatFilter, expFilt);
          chk(cfg[0] ? (cfg[2] ? "R2 R9 inhibit" : "R3 half duplex inhibit") : "R1 disabled inhibit",
              txInhibit, expInh);
          @(negedge clk);
          chk("R4 one-cycle strobe", rxStatValid, 1'b0);
        end
      end
    end

    // Countdown of N slot ticks
    cfgPassCtl = 1'b0; cfgPromisc = 1'b0; cfgFullDuplex = 1'b1;
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk); cfgFlowEn = 1'b0;
      @(negedge clk); cfgFlowEn = 1'b1;
      sendFrame(0, 16'(n), 1'b1);
      for (int k = 1; k <= n; k++) begin
        repeat (2) @(negedge clk);
        chk("R2 no decrement without tick", txInhibit, 1'b1);
        tick();
        chk("R2 countdown", txInhibit, k < n);
      end
    end

    // Reload and zero release
    sendFrame(0, 16'h0003, 1'b1);
    tick();
    sendFrame(0, 16'h0005, 1'b1);
    for (int k = 1; k <= 5; k++) begin
      tick();
      chk("R7 reload count", txInhibit, k < 5);
    end
    sendFrame(0, 16'h0004, 1'b1);
    chk("R7 loaded", txInhibit, 1'b1);
    sendFrame(0, 16'h0000, 1'b1);
    chk("R7 zero release", txInhibit, 1'b0);
    sendFrame(0, 16'h0004, 1'b1);
    sendFrame(0, 16'h0009, 1'b0);
    repeat (4) tick();
    chk("R9 bad CRC no reload", txInhibit, 1'b0);
    sendFrame(0, 16'h0002, 1'b1);
    @(negedge clk); cfgFlowEn = 1'b0;
    @(negedge clk);
    chk("R1 disable clears inhibit", txInhibit, 1'b0);

    // Transmit handshake
    for (int dup = 0; dup < 2; dup++) begin
      cfgFullDuplex = dup[0];
      @(negedge clk); cfgFlowEn = 1'b0; fcSendReq = 1'b1;
      @(negedge clk); fcSendReq = 1'b0;
      chk("R1 request ignored when disabled", fcBusy, 1'b0);
      chk("R1 no transmit request", txFcReq, 1'b0);
      cfgFlowEn = 1'b1; fcSendReq = 1'b1;
      @(negedge clk); fcSendReq = 1'b0;
      chk("R8 busy after request", fcBusy, 1'b1);
      chk("R8 transmit request", txFcReq, 1'b1);
      chk("R8 kind", txFcBackpressure, !dup[0]);
      cfgFullDuplex = !dup[0]; fcSendReq = 1'b1;
      @(negedge clk); fcSendReq = 1'b0;
      chk("R10 kind unchanged while busy", txFcBackpressure, !dup[0]);
      repeat (3) @(negedge clk);
      chk("R8 busy held", fcBusy, 1'b1);
      txFcDone = 1'b1;
      @(negedge clk); txFcDone = 1'b0;
      chk("R8 busy cleared", fcBusy, 1'b0);
      chk("R8 request cleared", txFcReq, 1'b0);
      @(negedge clk);
      chk("R10 ignored request not queued", fcBusy, 1'b0);
    end

    finish();
  end

endmodule